// File: doc/BRIEF.md
# Condition Code Test Evaluator

This block turns a 5-bit condition selector and the current condition-flag word into one yes/no answer. A micro-operation sequencer uses that answer to decide whether a conditional micro-operation is carried out or dropped. The selectors cover an always test and a never test, single-flag tests, the unsigned below-or-equal test, the signed less-than and less-or-equal tests, and tests on a separate carry flag and a separate zero flag that emulation code keeps apart from the architectural ones.

The lower four selector bits choose one of sixteen base tests. The top selector bit inverts the result, so every code in the upper half is the exact negation of the code sixteen below it. Four base codes are kept back for string-related tests that have no defined behaviour. Those codes, and their inverted forms, raise an error indication and never report true. The bit position of each flag within the flag word is a parameter. A parameter also chooses whether the result comes straight from the inputs or from a register one clock later.

Top module: `cond_eval`

## Requirements
- R1: Selector 0 always gives cond_true=1, and selector 16 always gives cond_true=0, whatever the flag word holds.
- R2: Single-flag base codes give the value of one flag: 8 overflow, 9 carry, 10 zero, 12 sign, 13 parity. With the default layout these flags sit at bits 11, 0, 6, 7 and 2 of flags_in.
- R3: Compound base codes: 11 gives carry OR zero, 14 gives sign XOR overflow, and 15 gives (sign XOR overflow) OR zero.
- R4: Base code 1 gives the auxiliary carry flag and base code 2 gives the auxiliary zero flag (default bits 16 and 17). The architectural carry and zero flags have no effect on these codes.
- R5: Base code 3 gives NOT(NOT auxiliary-zero AND zero). Selector 19 therefore gives NOT auxiliary-zero AND zero.
- R6: For every legal base code b, selector 16+b gives the complement of what selector b gives for the same flag word.
- R7: Base codes 4 to 7, that is selectors 4-7 and 20-23, set illegal_cond=1 and force cond_true=0.
- R8: Every other selector leaves illegal_cond=0.
- R9: With OUT_REG=1 (the default), both outputs show the result for the inputs sampled at the previous rising clock edge, and they read 0 while rst_n is low. With OUT_REG=0, both outputs follow the inputs with no clock delay.
- R10: Bits of flags_in outside the seven parameterised flag positions have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| cond_sel | input | 5 | Condition selector: bits 3:0 choose the base test, bit 4 inverts it |
| flags_in | input | FLAG_W | Current condition-flag word |
| cond_true | output | 1 | Result of the selected test |
| illegal_cond | output | 1 | High when the selector names a reserved test |

## Verification
The bench builds two instances side by side. The first uses the defaults: a registered output, a 32-bit flag word and the default flag layout. Its expected results pass through a queue, so the one-cycle delay and the reset value are checked on their own. The second uses OUT_REG=0, a 24-bit flag word and a shuffled flag layout. This reaches the combinational variant and shows that the flag positions are really taken from the parameters and not from fixed bits. Random flag words and words with noise added in the unused bits run against all 32 selectors on both instances.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

   // Base tests chosen by the low selector bits; the order is decoded behaviour.
   typedef enum logic [3:0] {
      CT_ALWAYS       = 4'd0,
      CT_XCARRY       = 4'd1,
      CT_XZERO        = 4'd2,
      CT_XZERO_GATE   = 4'd3,
      CT_RSV0         = 4'd4,
      CT_RSV1         = 4'd5,
      CT_RSV2         = 4'd6,
      CT_RSV3         = 4'd7,
      CT_OVF          = 4'd8,
      CT_CARRY        = 4'd9,
      CT_ZERO         = 4'd10,
      CT_BELOW_EQ     = 4'd11,
      CT_SIGN         = 4'd12,
      CT_PARITY       = 4'd13,
      CT_LESS         = 4'd14,
      CT_LESS_EQ      = 4'd15
   } cc_test_e;

   typedef struct packed {
      logic carry;
      logic parity;
      logic zero;
      logic sign;
      logic ovf;
      logic xcarry;
      logic xzero;
   } cc_flags_t;

   localparam int CC_NUM_FLAGS = 7;

   // True when all flag positions are inside the word and no two coincide.
   function automatic bit cc_pos_ok(input int w, input int p0, input int p1,
                                    input int p2, input int p3, input int p4,
                                    input int p5, input int p6);
      int p [CC_NUM_FLAGS];
      p = '{p0, p1, p2, p3, p4, p5, p6};
      for (int i = 0; i < CC_NUM_FLAGS; i++) begin
         if (p[i] < 0 || p[i] >= w) return 1'b0;
         for (int j = 0; j < i; j++) begin
            if (p[i] == p[j]) return 1'b0;
         end
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/cond_flag_pick.sv
module cond_flag_pick
   import cond_eval_pkg::*;
#(
   parameter int FLAG_W      = 32,
   parameter int CARRY_POS   = 0,
   parameter int PARITY_POS  = 2,
   parameter int ZERO_POS    = 6,
   parameter int SIGN_POS    = 7,
   parameter int OVF_POS     = 11,
   parameter int XCARRY_POS  = 16,
   parameter int XZERO_POS   = 17
) (
   input  logic [FLAG_W-1:0] flags_in,
   output cc_flags_t         picked
);

   localparam logic [FLAG_W-1:0] ONE = {{(FLAG_W-1){1'b0}}, 1'b1};
   localparam int POS [CC_NUM_FLAGS] = '{CARRY_POS, PARITY_POS, ZERO_POS,
                                         SIGN_POS, OVF_POS, XCARRY_POS,
                                         XZERO_POS};

   generate
      if (FLAG_W < CC_NUM_FLAGS || FLAG_W > 64) begin : g_bad_width
         $error("cond_flag_pick: FLAG_W out of range");
      end
      if (!cc_pos_ok(FLAG_W, CARRY_POS, PARITY_POS, ZERO_POS, SIGN_POS,
                     OVF_POS, XCARRY_POS, XZERO_POS)) begin : g_bad_pos
         $error("cond_flag_pick: flag positions overlap or exceed FLAG_W");
      end
   endgenerate

   // One-hot mask per flag, reduced after masking: every word bit feeds logic.
   logic [CC_NUM_FLAGS-1:0] hit;

   generate
      for (genvar k = 0; k < CC_NUM_FLAGS; k++) begin : g_pick
         localparam logic [FLAG_W-1:0] MASK = ONE << POS[k];
         assign hit[k] = |(flags_in & MASK);
      end
   endgenerate

   assign picked.carry  = hit[0];
   assign picked.parity = hit[1];
   assign picked.zero   = hit[2];
   assign picked.sign   = hit[3];
   assign picked.ovf    = hit[4];
   assign picked.xcarry = hit[5];
   assign picked.xzero  = hit[6];

endmodule

// File: rtl/cond_base_mux.sv
module cond_base_mux
   import cond_eval_pkg::*;
#(
   parameter int BASE_W = 4
) (
   input  logic [BASE_W-1:0] base_sel,
   input  cc_flags_t         flg,
   output logic              base_true,
   output logic              reserved
);

   generate
      if (BASE_W != $bits(cc_test_e)) begin : g_bad_base
         $error("cond_base_mux: BASE_W must match the test encoding");
      end
   endgenerate

   cc_test_e sel_e;
   assign sel_e = cc_test_e'(base_sel);

   always_comb begin
      base_true = 1'b0;
      reserved  = 1'b0;
      case (sel_e)
         CT_ALWAYS:     base_true = 1'b1;
         CT_XCARRY:     base_true = flg.xcarry;
         CT_XZERO:      base_true = flg.xzero;
         CT_XZERO_GATE: base_true = !(!flg.xzero && flg.zero);
         CT_RSV0, CT_RSV1, CT_RSV2, CT_RSV3: reserved = 1'b1;
         CT_OVF:        base_true = flg.ovf;
         CT_CARRY:      base_true = flg.carry;
         CT_ZERO:       base_true = flg.zero;
         CT_BELOW_EQ:   base_true = flg.carry | flg.zero;
         CT_SIGN:       base_true = flg.sign;
         CT_PARITY:     base_true = flg.parity;
         CT_LESS:       base_true = flg.sign ^ flg.ovf;
         CT_LESS_EQ:    base_true = (flg.sign ^ flg.ovf) | flg.zero;
         default: begin
            base_true = 1'b0;
            reserved  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cond_polarity.sv
module cond_polarity #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_true,
   input  logic reserved,
   input  logic invert,
   output logic cond_true,
   output logic illegal_cond
);

   logic next_true;
   assign next_true = reserved ? 1'b0 : (base_true ^ invert);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cond_true    <= 1'b0;
               illegal_cond <= 1'b0;
            end else begin
               cond_true    <= next_true;
               illegal_cond <= reserved;
            end
         end
      end else begin : g_comb
         assign cond_true    = next_true;
         assign illegal_cond = reserved;
      end
   endgenerate

endmodule

// File: rtl/cond_eval.sv
module cond_eval
   import cond_eval_pkg::*;
#(
   parameter int FLAG_W      = 32,
   parameter bit OUT_REG     = 1'b1,
   parameter int CARRY_POS   = 0,
   parameter int PARITY_POS  = 2,
   parameter int ZERO_POS    = 6,
   parameter int SIGN_POS    = 7,
   parameter int OVF_POS     = 11,
   parameter int XCARRY_POS  = 16,
   parameter int XZERO_POS   = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        cond_sel,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              cond_true,
   output logic              illegal_cond
);

   localparam int SEL_W  = 5;
   localparam int BASE_W = SEL_W - 1;

   cc_flags_t flg;
   logic      base_true;
   logic      reserved;

   cond_flag_pick #(
      .FLAG_W     (FLAG_W),
      .CARRY_POS  (CARRY_POS),
      .PARITY_POS (PARITY_POS),
      .ZERO_POS   (ZERO_POS),
      .SIGN_POS   (SIGN_POS),
      .OVF_POS    (OVF_POS),
      .XCARRY_POS (XCARRY_POS),
      .XZERO_POS  (XZERO_POS)
   ) u_pick (
      .flags_in (flags_in),
      .picked   (flg)
   );

   cond_base_mux #(
      .BASE_W (BASE_W)
   ) u_mux (
      .base_sel  (cond_sel[BASE_W-1:0]),
      .flg       (flg),
      .base_true (base_true),
      .reserved  (reserved)
   );

   cond_polarity #(
      .OUT_REG (OUT_REG)
   ) u_pol (
      .clk          (clk),
      .rst_n        (rst_n),
      .base_true    (base_true),
      .reserved     (reserved),
      .invert       (cond_sel[SEL_W-1]),
      .cond_true    (cond_true),
      .illegal_cond (illegal_cond)
   );

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] cond_sel,
   input logic       cond_true,
   input logic       illegal_cond
);

   // Error indication and a true result never appear together.
   assert_reserved_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_cond |-> !cond_true);

   generate
      if (OUT_REG) begin : g_seq
         assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel[3:2] == 2'b01) |=> illegal_cond);
         assert_legal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel[3:2] != 2'b01) |=> !illegal_cond);
         assert_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel == 5'd0) |=> cond_true);
         assert_never_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel == 5'd16) |=> !cond_true);
      end else begin : g_now
         assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel[3:2] == 2'b01) |-> illegal_cond);
         assert_legal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel[3:2] != 2'b01) |-> !illegal_cond);
         assert_always_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel == 5'd0) |-> cond_true);
         assert_never_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_sel == 5'd16) |-> !cond_true);
      end
   endgenerate

endmodule

bind cond_eval cond_eval_chk #(.OUT_REG(OUT_REG)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cond_sel     (cond_sel),
   .cond_true    (cond_true),
   .illegal_cond (illegal_cond)
);

// File: tb/cond_eval_tb_top.sv
module cond_eval_tb_top;

   localparam int CLK_PERIOD = 10;

   // Alternate layout for the combinational instance.
   localparam int A_W = 24;
   localparam int A_C = 5, A_P = 0, A_Z = 9, A_S = 1, A_O = 20, A_XC = 14, A_XZ = 23;
   // Default layout.
   localparam int D_C = 0, D_P = 2, D_Z = 6, D_S = 7, D_O = 11, D_XC = 16, D_XZ = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cond_sel = 5'd0;
   logic [31:0] flags = 32'd0;
   logic        r_true, r_ill, c_true, c_ill;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [1:0] exp_q [$];
   string      tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_eval dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cond_sel     (cond_sel),
      .flags_in     (flags),
      .cond_true    (r_true),
      .illegal_cond (r_ill)
   );

   cond_eval #(
      .FLAG_W (A_W), .OUT_REG (1'b0),
      .CARRY_POS (A_C), .PARITY_POS (A_P), .ZERO_POS (A_Z), .SIGN_POS (A_S),
      .OVF_POS (A_O), .XCARRY_POS (A_XC), .XZERO_POS (A_XZ)
   ) dut_comb_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cond_sel     (cond_sel),
      .flags_in     (flags[A_W-1:0]),
      .cond_true    (c_true),
      .illegal_cond (c_ill)
   );

   // Behavioural expectation; returns {true, illegal}.
   function automatic logic [1:0] model(input int sel, input logic [31:0] f,
                                        input int pc, input int pp, input int pz,
                                        input int ps, input int po, input int pxc,
                                        input int pxz);
      int  lo = sel % 16;
      bit  c = f[pc], p = f[pp], z = f[pz], s = f[ps], o = f[po];
      bit  xc = f[pxc], xz = f[pxz];
      bit  r = 1'b0;
      if (lo >= 4 && lo <= 7) return 2'b01;
      if      (lo == 0)  r = 1'b1;
      else if (lo == 1)  r = xc;
      else if (lo == 2)  r = xz;
      else if (lo == 3)  r = xz || !z;
      else if (lo == 8)  r = o;
      else if (lo == 9)  r = c;
      else if (lo == 10) r = z;
      else if (lo == 11) r = c || z;
      else if (lo == 12) r = s;
      else if (lo == 13) r = p;
      else if (lo == 14) r = (s != o);
      else               r = (s != o) || z;
      if (sel >= 16) r = !r;
      return {r, 1'b0};
   endfunction

   function automatic string tag_of(input int sel);
      int lo = sel % 16;
      if (lo >= 4 && lo <= 7) return "R7";
      if (sel >= 17) return "R6";
      if (lo == 0) return "R1";
      if (lo == 1 || lo == 2) return "R4";
      if (lo == 3) return "R5";
      if (lo == 11 || lo == 14 || lo == 15) return "R3";
      return "R2";
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic step(input int sel, input logic [31:0] f, input string force_tag);
      logic [1:0] ce, re, rprev;
      string      t, tprev;
      @(negedge clk);
      cond_sel = sel[4:0];
      flags = f;
      #1;
      t = (force_tag != "") ? force_tag : tag_of(sel);
      ce = model(sel, f, A_C, A_P, A_Z, A_S, A_O, A_XC, A_XZ);
      check(t, $sformatf("comb true sel=%0d", sel), c_true, ce[1]);
      check((ce[0] ? "R7" : "R8"), $sformatf("comb illegal sel=%0d", sel), c_ill, ce[0]);
      rprev = exp_q.pop_front();
      tprev = tag_q.pop_front();
      check({"R9 ", tprev}, "registered true", r_true, rprev[1]);
      check({"R9 ", (rprev[0] ? "R7" : "R8")}, "registered illegal", r_ill, rprev[0]);
      re = model(sel, f, D_C, D_P, D_Z, D_S, D_O, D_XC, D_XZ);
      exp_q.push_back(re);
      tag_q.push_back(t);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R9", "reset true", r_true, 1'b0);
      check("R9", "reset illegal", r_ill, 1'b0);
      rst_n = 1'b1;
      exp_q.push_back(2'b10);
      tag_q.push_back("R1");

      // Fixed words, then random words, over every selector.
      for (int s = 0; s < 32; s++) begin
         step(s, 32'h0000_0000, "");
         step(s, 32'hFFFF_FFFF, "");
         for (int k = 0; k < 8; k++) step(s, $urandom, "");
      end

      // R5: auxiliary zero gating the zero flag, both polarities, all four cases.
      for (int v = 0; v < 4; v++) begin
         logic [31:0] w = 32'd0;
         w[D_Z] = v[0]; w[D_XZ] = v[1]; w[A_Z] = v[0]; w[A_XZ] = v[1];
         step(3, w, "R5");
         step(19, w, "R5");
      end

      // R4: architectural carry/zero toggled under fixed auxiliary flags.
      for (int v = 0; v < 8; v++) begin
         logic [31:0] w = 32'd0;
         w[D_C] = v[0]; w[D_Z] = v[1]; w[D_XC] = v[2]; w[D_XZ] = v[2];
         w[A_C] = v[0]; w[A_Z] = v[1]; w[A_XC] = v[2]; w[A_XZ] = v[2];
         step(1, w, "R4");
         step(2, w, "R4");
      end

      // R10: noise in bits outside both layouts' flag positions.
      for (int s = 0; s < 32; s++) begin
         logic [31:0] used = 32'd0;
         logic [31:0] base = $urandom;
         used[D_C] = 1; used[D_P] = 1; used[D_Z] = 1; used[D_S] = 1;
         used[D_O] = 1; used[D_XC] = 1; used[D_XZ] = 1;
         used[A_C] = 1; used[A_P] = 1; used[A_Z] = 1; used[A_S] = 1;
         used[A_O] = 1; used[A_XC] = 1; used[A_XZ] = 1;
         step(s, base & used, "R10");
         step(s, (base & used) | (~used & $urandom), "R10");
         step(s, (base & used) | ~used, "R10");
      end

      step(0, 32'd0, "R1");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule